// File: doc/BRIEF.md
# Regular Conversion Sequence Controller

This block walks an analog-to-digital converter core through a programmed list of up to sixteen channel slots. For each conversion it drives a channel number together with a one-cycle start pulse toward the core. It then waits for the core's end-of-sampling and done pulses and captures the returned 16-bit result in a data register. Status flags report end of sampling, end of conversion, end of sequence and overrun. Software owns a start bit and a stop bit through single-cycle command pulses. The flags are cleared by write-one pulses, and the end-of-conversion flag is also cleared by a read strobe on the data register.

A run is started either by software or by an external trigger. It can cover the whole list once (single), repeat it without pause (continuous), or convert it in small groups, one group per trigger (discontinuous). A stop command abandons the conversion in flight: its result never reaches the data register or the flags, and the controller returns to idle once the core has finished.

Top module: `regseq_ctrl`

## Requirements
- R1: Slot k of `cfg_slots` is the 5-bit field at bits [5k+4:5k]. A sequence runs slots 0, 1, ... up to slot `cfg_len` in that order, so the sequence has `cfg_len`+1 conversions, and `adc_chan` carries the slot's channel while `adc_start` is high.
- R2: `adc_start` is a single-cycle pulse. In software-trigger mode (`cfg_ext`=0) a `sw_start` pulse seen while idle sets `start_bit`, and the first pulse follows on the next cycle. With `cfg_ext`=1 the same pulse only arms the block, and each accepted `ext_trig` is followed one cycle later by a conversion start.
- R3: An accepted `adc_done` loads `adc_data` into `data_reg` and sets `flag_eoc`. A `clr_eoc` or `dr_read` pulse clears it, and a set in the same cycle takes priority over a clear.
- R4: `flag_eos` is set when the conversion of slot `cfg_len` is accepted, and a `clr_eos` pulse clears it.
- R5: `flag_ovr` is set when a conversion is accepted while `flag_eoc` is set and is not being cleared in that cycle. The data register still takes the new result, and a `clr_ovr` pulse clears the flag.
- R6: With `cfg_cont`=1 the sequence restarts from slot 0 right after its last conversion, with no trigger. Once `cfg_cont` is cleared, the run ends at the next sequence end.
- R7: With `cfg_disc`=1 each trigger converts `cfg_grp`+1 slots, or fewer if the sequence end comes first. The next trigger carries on from the following slot, and the position wraps to slot 0 after slot `cfg_len`. Continuous and discontinuous mode are never enabled together.
- R8: In single software-trigger mode, `start_bit` falls in the same cycle that `flag_eos` rises. In external-trigger mode it stays set after the sequence ends.
- R9: A `sw_stop` pulse while `start_bit` is set raises `stop_bit` on the next cycle. A conversion in flight is then discarded: no flag changes, `data_reg` keeps its value and no further `adc_start` is issued. Both bits clear on the cycle after the core's done pulse, or one cycle after `stop_bit` rises if nothing is in flight.
- R10: `flag_eosmp` is set by an `adc_smp_done` pulse during a live (not aborting) conversion, and a `clr_eosmp` pulse clears it.
- R11: After a synchronous reset all flags, `start_bit`, `stop_bit`, `adc_start` and `data_reg` are zero.
- R12: `sw_start` has no effect on a running sequence in single software mode, and `sw_stop` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slots | input | 80 | Sixteen 5-bit channel slots, slot k at [5k+4:5k] |
| cfg_len | input | 4 | Index of the last slot in the sequence |
| cfg_cont | input | 1 | Continuous mode |
| cfg_disc | input | 1 | Discontinuous mode |
| cfg_grp | input | 3 | Slots per trigger minus one in discontinuous mode |
| cfg_ext | input | 1 | 1 = external trigger, 0 = software trigger |
| sw_start | input | 1 | Start command pulse |
| sw_stop | input | 1 | Stop command pulse |
| ext_trig | input | 1 | External trigger pulse |
| clr_eosmp | input | 1 | Write-one clear of end-of-sampling flag |
| clr_eoc | input | 1 | Write-one clear of end-of-conversion flag |
| clr_eos | input | 1 | Write-one clear of end-of-sequence flag |
| clr_ovr | input | 1 | Write-one clear of overrun flag |
| dr_read | input | 1 | Data register read strobe |
| adc_start | output | 1 | Conversion start pulse to the core |
| adc_chan | output | 5 | Channel for the conversion being started |
| adc_smp_done | input | 1 | Core end-of-sampling pulse |
| adc_done | input | 1 | Core conversion-done pulse |
| adc_data | input | 16 | Core result, valid with adc_done |
| start_bit | output | 1 | Start bit |
| stop_bit | output | 1 | Stop bit |
| data_reg | output | 16 | Last accepted result |
| flag_eosmp | output | 1 | End of sampling flag |
| flag_eoc | output | 1 | End of conversion flag |
| flag_eos | output | 1 | End of sequence flag |
| flag_ovr | output | 1 | Overrun flag |

## Verification
The bench pushes four conversions through without reading the data register. A design that counts a conversion as overrun only when the flag was cleared, or that keeps the old result on overrun, shows the wrong flag or data value. Discontinuous runs with groups of two over five slots check the short last group, the sequence-end flag and the wrap back to slot 0; an off-by-one group count or a pointer that restarts on every trigger gives the wrong conversion count or channel. A stop is issued in the middle of a conversion and again while only armed. A design that lets the discarded result through, launches once more, or leaves the stop bit stuck then disagrees with the cycle model. Turning continuous mode off mid-run must end on a sequence boundary, and a second start pulse during a single run must not add conversions.

// File: rtl/regseq_pkg.sv
// Shared types for the regular conversion sequence controller.
package regseq_pkg;
    // Sequencer states: idle, armed awaiting a trigger, issuing a start, converting
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/regseq_engine.sv
// Sequencing engine: owns start/stop bits, slot pointer and group counter,
// issues conversion starts and qualifies core responses.
// Assumes the core answers each start with exactly one done pulse and that
// configuration only changes while start_bit is low (cfg_cont may drop any time).
module regseq_engine
    import regseq_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int CH_W   = 5,
    parameter int DISC_W = 3,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SLOTS*CH_W-1:0] cfg_slots,
    input  logic [PTR_W-1:0]      cfg_len,
    input  logic                  cfg_cont,
    input  logic                  cfg_disc,
    input  logic [DISC_W-1:0]     cfg_grp,
    input  logic                  cfg_ext,
    input  logic                  sw_start,
    input  logic                  sw_stop,
    input  logic                  ext_trig,
    input  logic                  adc_smp_done,
    input  logic                  adc_done,
    output logic                  start_bit,
    output logic                  stop_bit,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_chan,
    output logic                  conv_ok,
    output logic                  smp_ok,
    output logic                  seq_end
);
    seq_state_t          state_q, state_d;
    logic [PTR_W-1:0]    ptr_q, ptr_d;
    logic [DISC_W-1:0]   grp_q, grp_d;
    logic                start_q, start_d, stop_q, stop_d;
    logic                go_idle, trig, at_last, grp_full;
    logic [CH_W-1:0]     slot_ch [SLOTS];

    // Unpack the flat slot vector into one channel field per slot
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_ch[s] = cfg_slots[s*CH_W +: CH_W];
    end

    assign trig      = cfg_ext ? ext_trig : sw_start;
    assign at_last   = (ptr_q == cfg_len);
    assign grp_full  = cfg_disc && (grp_q == cfg_grp);
    assign conv_ok   = (state_q == ST_CONV) && adc_done && !stop_q;
    assign smp_ok    = (state_q == ST_CONV) && adc_smp_done && !stop_q;
    assign seq_end   = conv_ok && at_last;
    assign adc_start = (state_q == ST_LAUNCH) && !stop_q;
    assign adc_chan  = slot_ch[ptr_q];
    assign start_bit = start_q;
    assign stop_bit  = stop_q;

    // Next-state decode for the sequencer, including abort and auto-clear
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        grp_d   = grp_q;
        start_d = start_q;
        stop_d  = stop_q | (sw_stop & start_q);
        go_idle = 1'b0;
        if (stop_q) begin
            if (state_q != ST_CONV || adc_done) go_idle = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: if (sw_start) begin
                    start_d = 1'b1;
                    state_d = cfg_ext ? ST_ARMED : ST_LAUNCH;
                    grp_d   = '0;
                end
                ST_ARMED: if (trig) begin
                    state_d = ST_LAUNCH;
                    grp_d   = '0;
                end
                ST_LAUNCH: state_d = ST_CONV;
                ST_CONV: if (adc_done) begin
                    grp_d = DISC_W'(grp_q + 1'b1);
                    ptr_d = at_last ? '0 : PTR_W'(ptr_q + 1'b1);
                    if (at_last) begin
                        if (cfg_cont) begin
                            state_d = ST_LAUNCH;
                            grp_d   = '0;
                        end else if (cfg_ext) begin
                            state_d = ST_ARMED;
                        end else begin
                            go_idle = 1'b1;
                        end
                    end else if (grp_full) begin
                        state_d = ST_ARMED;
                    end else begin
                        state_d = ST_LAUNCH;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (go_idle) begin
            state_d = ST_IDLE;
            start_d = 1'b0;
            stop_d  = 1'b0;
            ptr_d   = '0;
        end
    end

    // Sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            grp_q   <= '0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            grp_q   <= grp_d;
            start_q <= start_d;
            stop_q  <= stop_d;
        end
    end

    // A stop bit only exists inside a running sequence
    p_stop_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> start_q);
    // A done pulse during an abort ends the run on the next cycle
    p_abort_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && adc_done) |=> (!start_q && !stop_q));
    // The start bit only falls at an abort or at a sequence end
    p_start_autoclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> ($past(stop_q) || $past(seq_end)));
endmodule

// File: rtl/regseq_status.sv
// Status flags and data register. Set always takes priority over a clear
// arriving in the same cycle. Assumes conv_ok/smp_ok already exclude aborts.
module regseq_status #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_ok,
    input  logic              smp_ok,
    input  logic              seq_end,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              clr_eosmp,
    input  logic              clr_eoc,
    input  logic              clr_eos,
    input  logic              clr_ovr,
    input  logic              dr_read,
    output logic [DATA_W-1:0] data_reg,
    output logic              flag_eosmp,
    output logic              flag_eoc,
    output logic              flag_eos,
    output logic              flag_ovr
);
    logic [DATA_W-1:0] data_q;
    logic eoc_q, eos_q, ovr_q, smp_q, eoc_drop;

    assign eoc_drop = clr_eoc | dr_read;

    // Capture results and maintain the four status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            eoc_q  <= 1'b0;
            eos_q  <= 1'b0;
            ovr_q  <= 1'b0;
            smp_q  <= 1'b0;
        end else begin
            if (conv_ok) data_q <= adc_data;
            eoc_q <= conv_ok | (eoc_q & ~eoc_drop);
            ovr_q <= (conv_ok & eoc_q & ~eoc_drop) | (ovr_q & ~clr_ovr);
            eos_q <= seq_end | (eos_q & ~clr_eos);
            smp_q <= smp_ok | (smp_q & ~clr_eosmp);
        end
    end

    assign data_reg   = data_q;
    assign flag_eoc   = eoc_q;
    assign flag_eos   = eos_q;
    assign flag_ovr   = ovr_q;
    assign flag_eosmp = smp_q;

    p_eoc_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_q) |-> $past(conv_ok));
    p_ovr_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> ($past(eoc_q) && $past(conv_ok)));
    p_eos_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos_q) |-> $past(seq_end));
    p_smp_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_q) |-> $past(smp_ok));
endmodule

// File: rtl/regseq_ctrl.sv
// Regular conversion sequence controller top: joins the sequencing engine
// and the status/data block. Assumes single-cycle command and trigger pulses.
module regseq_ctrl #(
    parameter int SLOTS  = 16,
    parameter int CH_W   = 5,
    parameter int DISC_W = 3,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SLOTS*CH_W-1:0] cfg_slots,
    input  logic [PTR_W-1:0]      cfg_len,
    input  logic                  cfg_cont,
    input  logic                  cfg_disc,
    input  logic [DISC_W-1:0]     cfg_grp,
    input  logic                  cfg_ext,
    input  logic                  sw_start,
    input  logic                  sw_stop,
    input  logic                  ext_trig,
    input  logic                  clr_eosmp,
    input  logic                  clr_eoc,
    input  logic                  clr_eos,
    input  logic                  clr_ovr,
    input  logic                  dr_read,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_chan,
    input  logic                  adc_smp_done,
    input  logic                  adc_done,
    input  logic [DATA_W-1:0]     adc_data,
    output logic                  start_bit,
    output logic                  stop_bit,
    output logic [DATA_W-1:0]     data_reg,
    output logic                  flag_eosmp,
    output logic                  flag_eoc,
    output logic                  flag_eos,
    output logic                  flag_ovr
);
    logic conv_ok, smp_ok, seq_end;

    regseq_engine #(.SLOTS(SLOTS), .CH_W(CH_W), .DISC_W(DISC_W)) u_engine (
        .clk, .rst_n, .cfg_slots, .cfg_len, .cfg_cont, .cfg_disc, .cfg_grp,
        .cfg_ext, .sw_start, .sw_stop, .ext_trig, .adc_smp_done, .adc_done,
        .start_bit, .stop_bit, .adc_start, .adc_chan, .conv_ok, .smp_ok,
        .seq_end
    );

    regseq_status #(.DATA_W(DATA_W)) u_status (
        .clk, .rst_n, .conv_ok, .smp_ok, .seq_end, .adc_data, .clr_eosmp,
        .clr_eoc, .clr_eos, .clr_ovr, .dr_read, .data_reg, .flag_eosmp,
        .flag_eoc, .flag_eos, .flag_ovr
    );
endmodule

// File: tb/tb_regseq_ctrl.sv
`timescale 1ns/1ps
module tb_regseq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [79:0] cfg_slots;
    logic [3:0]  cfg_len = 4'd3;
    logic cfg_cont = 0, cfg_disc = 0, cfg_ext = 0;
    logic [2:0] cfg_grp = 3'd0;
    logic sw_start = 0, sw_stop = 0, ext_trig = 0;
    logic clr_eosmp = 0, clr_eoc = 0, clr_eos = 0, clr_ovr = 0, dr_read = 0;
    logic adc_start, adc_smp_done = 0, adc_done = 0;
    logic [4:0]  adc_chan;
    logic [15:0] adc_data = 16'h0;
    logic start_bit, stop_bit, flag_eosmp, flag_eoc, flag_eos, flag_ovr;
    logic [15:0] data_reg;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int slot [16];
    int n_conv = 0;
    int chq [$];
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    regseq_ctrl dut (.*);

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Core model: smp pulse 2 cycles and done 4 cycles after a start
    int core_cnt = 0;
    bit core_busy = 0;
    int core_ch = 0;
    always @(negedge clk) begin
        adc_done = 0;
        adc_smp_done = 0;
        if (core_busy) begin
            core_cnt--;
            if (core_cnt == 2) adc_smp_done = 1;
            if (core_cnt == 0) begin
                adc_done = 1;
                core_busy = 0;
                adc_data = 16'((core_ch << 11) | (n_conv & 16'h7ff));
            end
        end
        if (adc_start && !core_busy && rst_n) begin
            core_busy = 1;
            core_cnt = 4;
            core_ch = adc_chan;
            n_conv++;
            chq.push_back(int'(adc_chan));
        end
    end

    // Behavioural reference model, updated at the same edge as the design
    int m_ph = 0, m_ptr = 0, m_g = 0;
    bit m_start = 0, m_stop = 0, m_eoc = 0, m_eos = 0, m_ovr = 0, m_smp = 0;
    int m_dr = 0;
    always @(posedge clk) begin
        bit acc, rd, nstop, idle;
        if (!rst_n) begin
            m_ph = 0; m_ptr = 0; m_g = 0; m_start = 0; m_stop = 0;
            m_eoc = 0; m_eos = 0; m_ovr = 0; m_smp = 0; m_dr = 0;
        end else begin
            acc = (m_ph == 3) && adc_done && !m_stop;
            rd  = clr_eoc || dr_read;
            m_ovr = (acc && m_eoc && !rd) || (m_ovr && !clr_ovr);
            m_eoc = acc || (m_eoc && !rd);
            m_eos = (acc && m_ptr == int'(cfg_len)) || (m_eos && !clr_eos);
            m_smp = ((m_ph == 3) && adc_smp_done && !m_stop) || (m_smp && !clr_eosmp);
            if (acc) m_dr = int'(adc_data);
            nstop = m_stop || (sw_stop && m_start);
            idle = 0;
            if (m_stop) begin
                if (m_ph != 3 || adc_done) idle = 1;
            end else if (m_ph == 0) begin
                if (sw_start) begin m_start = 1; m_ph = cfg_ext ? 1 : 2; m_g = 0; end
            end else if (m_ph == 1) begin
                if (cfg_ext ? ext_trig : sw_start) begin m_ph = 2; m_g = 0; end
            end else if (m_ph == 2) begin
                m_ph = 3;
            end else if (adc_done) begin
                if (m_ptr == int'(cfg_len)) begin
                    m_ptr = 0;
                    if (cfg_cont) begin m_ph = 2; m_g = 0; end
                    else if (cfg_ext) m_ph = 1;
                    else idle = 1;
                end else begin
                    m_ptr++;
                    m_ph = (cfg_disc && m_g == int'(cfg_grp)) ? 1 : 2;
                    m_g++;
                end
            end
            m_stop = nstop;
            if (idle) begin m_ph = 0; m_start = 0; m_stop = 0; m_ptr = 0; end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8 start_bit", start_bit, m_start);
            chk("R9 stop_bit", stop_bit, m_stop);
            chk("R2 adc_start", adc_start, (m_ph == 2) && !m_stop);
            if (adc_start) chk("R1 adc_chan", adc_chan, slot[m_ptr]);
            chk("R3 data_reg", data_reg, m_dr);
            chk("R3 flag_eoc", flag_eoc, m_eoc);
            chk("R4 flag_eos", flag_eos, m_eos);
            chk("R5 flag_ovr", flag_ovr, m_ovr);
            chk("R10 flag_eosmp", flag_eosmp, m_smp);
        end
    end

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            summary_and_end();
        end
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    task automatic clr_all();
        @(negedge clk); clr_eoc = 1; clr_eos = 1; clr_ovr = 1; clr_eosmp = 1;
        @(negedge clk); clr_eoc = 0; clr_eos = 0; clr_ovr = 0; clr_eosmp = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && start_bit; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n0, d0;
        for (int i = 0; i < 16; i++) begin
            slot[i] = (i * 7 + 3) % 20;
            cfg_slots[i*5 +: 5] = 5'(slot[i]);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // R11 reset state
        chk("R11 reset flags", {flag_eoc, flag_eos, flag_ovr, flag_eosmp}, 0);
        chk("R11 reset bits", {start_bit, stop_bit, adc_start}, 0);
        chk("R11 reset data", data_reg, 0);

        // Single software run, no reads: overrun builds up (R1, R4, R5)
        n0 = n_conv;
        pulse(sw_start);
        wait_idle();
        chk("R1 conversions = len+1", n_conv - n0, 4);
        chk("R5 overrun after unread results", flag_ovr, 1);
        chk("R4 end of sequence", flag_eos, 1);
        clr_all();
        chk("R3 clear all flags", {flag_eoc, flag_eos, flag_ovr, flag_eosmp}, 0);

        // Single run with reads, plus a redundant start (R3, R12)
        cfg_len = 4'd2;
        n0 = n_conv;
        pulse(sw_start);
        for (int i = 0; i < 200 && start_bit; i++) begin
            @(negedge clk);
            dr_read = flag_eoc;
            sw_start = (i == 3);
        end
        dr_read = 0; sw_start = 0;
        wait_idle();
        chk("R12 extra start adds nothing", n_conv - n0, 3);
        chk("R3 reads prevent overrun", flag_ovr, 0);
        pulse(sw_stop);
        @(negedge clk);
        chk("R12 stop ignored when idle", stop_bit, 0);
        clr_all();

        // Continuous mode, then switched off mid-run (R6)
        cfg_len = 4'd1; cfg_cont = 1;
        n0 = n_conv;
        pulse(sw_start);
        repeat (40) @(negedge clk);
        chk("R6 still running", start_bit, 1);
        chk("R6 restarted without trigger", (n_conv - n0) > 2, 1);
        cfg_cont = 0;
        wait_idle();
        chk("R6 ends on a sequence boundary", (n_conv - n0) % 2, 0);
        clr_all();

        // Discontinuous, external trigger, groups of two over five slots (R7, R2, R8)
        cfg_len = 4'd4; cfg_disc = 1; cfg_grp = 3'd1; cfg_ext = 1;
        n0 = n_conv;
        pulse(sw_start);
        repeat (6) @(negedge clk);
        chk("R2 armed waits for trigger", n_conv - n0, 0);
        pulse(ext_trig); repeat (25) @(negedge clk);
        chk("R7 first group", n_conv - n0, 2);
        pulse(ext_trig); repeat (25) @(negedge clk);
        chk("R7 second group", n_conv - n0, 4);
        pulse(ext_trig); repeat (25) @(negedge clk);
        chk("R7 short last group", n_conv - n0, 5);
        chk("R7 end of sequence", flag_eos, 1);
        chk("R8 start kept in external mode", start_bit, 1);
        pulse(ext_trig); repeat (25) @(negedge clk);
        chk("R7 wrap group", n_conv - n0, 7);
        chk("R7 wrap to slot 0", chq[n0 + 5], slot[0]);
        pulse(sw_stop);
        @(negedge clk); @(negedge clk);
        chk("R9 stop while armed", {start_bit, stop_bit}, 0);
        cfg_disc = 0; cfg_ext = 0; cfg_grp = 3'd0;
        clr_all();

        // Stop in the middle of a conversion (R9)
        cfg_len = 4'd3;
        n0 = n_conv;
        pulse(sw_start);
        for (int i = 0; i < 100 && (n_conv - n0) < 2; i++) @(negedge clk);
        d0 = int'(data_reg);
        pulse(sw_stop);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R9 result discarded", data_reg, d0);
        chk("R9 no launch after stop", n_conv - n0, 2);
        chk("R9 bits cleared", {start_bit, stop_bit}, 0);

        repeat (5) @(negedge clk);
        summary_and_end();
    end
endmodule